// File: doc/BRIEF.md
# Three-Wire Serial Programming Receiver

This block takes configuration words from a slow, one-way serial link made of a data line, a serial clock and an active-low enable. It runs entirely in the system clock domain. The three pins pass through two-flop synchronisers, and edges on the synchronised lines drive the logic. While the enable is low, each rising serial-clock edge shifts one data bit into a 21-bit window, most significant bit first. Only the newest 21 bits are kept, and the number of clocks is never counted.

When the enable returns high, the newest four bits are taken as an address and the 17 bits before them as a data value. A single load then writes that value into one of six parallel control latches. A downstream divider signals through `divider_read_busy` when it is sampling the latches. A load that falls inside that window is parked in a one-entry pending slot and carried out as soon as the window closes. A later request overwrites a parked one.

The address space also holds test-only codes and unmapped codes. A load to either kind changes no latch and raises a sticky error flag. An asynchronous active-low reset clears every latch and the flag.

Top module: `tw_prog_top`

## Requirements
- R1: After reset, every control latch in `cfg_q` reads zero and `addr_err` is 0.
- R2: Serial-clock edges that occur while `ser_en_n` is high shift nothing. If a frame is clocked with the enable high and an enable pulse with no clocks follows, the load uses the previously shifted bits.
- R3: Bits enter MSB first, and only the last 21 bits clocked in before the enable rises are used. Any earlier leading bits are discarded, whatever their number.
- R4: Of the 21 retained bits, the last four received form the address and the 17 before them form the data value, with the first of those 17 landing in data bit 16. Latch k (k = 0..5) occupies `cfg_q[17*k +: 17]` and answers to address k+1.
- R5: Each rising edge of the enable produces at most one load. That load writes only the addressed latch, overwriting its old value, and leaves every other latch unchanged.
- R6: The enable may rise while the serial clock is still high. The data shifted on the final rising serial edge is still used, and the serial-clock fall that follows with the enable high has no effect.
- R7: While `divider_read_busy` is 1, no latch changes. A request made during that time is applied once the signal returns to 0.
- R8: If several requests arrive while `divider_read_busy` is 1, only the newest is applied after release. The older ones write nothing.
- R9: Addresses 0 and 15 are reserved, and addresses 7 to 14 are unmapped. A load to any of them changes no latch and sets `addr_err` to 1.
- R10: `addr_err` stays at 1 until reset, including across later valid loads. Those valid loads still update their latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous to clk |
| ser_data | input | 1 | Serial data, sampled on rising ser_clk |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge requests a load |
| divider_read_busy | input | 1 | High while the divider samples the latches; loads are deferred |
| cfg_q | output | 102 | Six 17-bit control latches, latch k at bits 17*k+16 down to 17*k |
| addr_err | output | 1 | Sticky flag for loads to reserved or unmapped addresses |

## Verification
The assertions assume that `divider_read_busy` is synchronous to `clk`. They also assume that every level on the three serial pins lasts several system clocks, so that the synchronisers catch every edge. The data line must also be steady across each rising serial-clock edge.

The stimulus keeps to these assumptions. It holds each serial level for ten system clocks and changes data only at serial-clock falls. It moves `divider_read_busy` and the serial pins only at instants halfway between system clock edges.

// File: rtl/tw_prog_pkg.sv
package tw_prog_pkg;

  typedef enum logic [1:0] {
    SLOT_LATCH    = 2'd0,
    SLOT_RESERVED = 2'd1,
    SLOT_UNMAPPED = 2'd2
  } slot_kind_e;

  // Sort an address into latch, test-only or unused space.
  function automatic slot_kind_e classify_addr(
    input int unsigned a,
    input int unsigned base,
    input int unsigned num,
    input int unsigned rsv_lo,
    input int unsigned rsv_hi
  );
    if (a == rsv_lo || a == rsv_hi)
      return SLOT_RESERVED;
    else if (a >= base && a < base + num)
      return SLOT_LATCH;
    else
      return SLOT_UNMAPPED;
  endfunction

endpackage

// File: rtl/tw_prog_rstsync.sv
module tw_prog_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic st1_q;
  logic st2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st1_q <= 1'b0;
      st2_q <= 1'b0;
    end else begin
      st1_q <= 1'b1;
      st2_q <= st1_q;
    end
  end

  assign rst_n = st2_q;
endmodule

// File: rtl/tw_prog_sync.sv
module tw_prog_sync #(
  parameter int        W       = 1,
  parameter logic      RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= din[i];
        sync_q <= meta_q;
      end
    end

    assign dout[i] = sync_q;
  end
endmodule

// File: rtl/tw_prog_shifter.sv
module tw_prog_shifter #(
  parameter int SR_W = 21
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_s,
  input  logic            sdata_s,
  input  logic            en_n_s,
  output logic [SR_W-1:0] shift_q,
  output logic            load_req
);
  logic            sclk_d_q;
  logic            en_n_d_q;
  logic            sclk_rise;
  logic            shift_en;
  logic [SR_W-1:0] shift_nxt;

  // Next-state logic.
  always_comb begin
    sclk_rise = sclk_s & ~sclk_d_q;
    shift_en  = sclk_rise & ~en_n_s;
    shift_nxt = shift_q;
    if (shift_en)
      shift_nxt = {shift_q[SR_W-2:0], sdata_s};
    load_req  = en_n_s & ~en_n_d_q;
  end

  // Registers. The enable history resets to idle-high so that no load is
  // requested when reset is released.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      en_n_d_q <= 1'b1;
      shift_q  <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      en_n_d_q <= en_n_s;
      if (shift_en)
        shift_q <= shift_nxt;
    end
  end
endmodule

// File: rtl/tw_prog_commit.sv
module tw_prog_commit
  import tw_prog_pkg::*;
#(
  parameter int DATA_W    = 17,
  parameter int ADDR_W    = 4,
  parameter int NUM_REGS  = 6,
  parameter int BASE_ADDR = 1,
  parameter int RSV_LO    = 0,
  parameter int RSV_HI    = 15,
  localparam int SR_W     = DATA_W + ADDR_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load_req,
  input  logic [SR_W-1:0]            word,
  input  logic                       busy,
  output logic [NUM_REGS*DATA_W-1:0] cfg_q,
  output logic                       err_q,
  output logic [NUM_REGS-1:0]        latch_we,
  output logic                       pend_valid_q
);
  logic [SR_W-1:0]   pend_word_q;
  logic              pend_valid_nxt;
  logic [SR_W-1:0]   pend_word_nxt;
  logic              fire;
  logic [SR_W-1:0]   fire_word;
  logic [ADDR_W-1:0] fire_addr;
  logic [DATA_W-1:0] fire_data;
  slot_kind_e        fire_kind;
  logic              err_nxt;

  // Next-state logic: select a fresh or parked request and decode it.
  always_comb begin
    fire           = ~busy & (load_req | pend_valid_q);
    fire_word      = load_req ? word : pend_word_q;
    fire_addr      = fire_word[ADDR_W-1:0];
    fire_data      = fire_word[SR_W-1:ADDR_W];
    fire_kind      = classify_addr(32'(fire_addr), BASE_ADDR, NUM_REGS,
                                   RSV_LO, RSV_HI);
    pend_valid_nxt = pend_valid_q;
    pend_word_nxt  = pend_word_q;
    if (busy && load_req) begin
      pend_valid_nxt = 1'b1;
      pend_word_nxt  = word;
    end else if (!busy) begin
      pend_valid_nxt = 1'b0;
    end
    err_nxt = err_q | (fire & (fire_kind != SLOT_LATCH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_word_q  <= '0;
      err_q        <= 1'b0;
    end else begin
      pend_valid_q <= pend_valid_nxt;
      if (busy && load_req)
        pend_word_q <= pend_word_nxt;
      err_q <= err_nxt;
    end
  end

  // One latch for each mapped address.
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_latch
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + k);
    logic [DATA_W-1:0] val_q;

    assign latch_we[k] = fire & (fire_kind == SLOT_LATCH) &
                         (fire_addr == MY_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        val_q <= '0;
      else if (latch_we[k])
        val_q <= fire_data;
    end

    assign cfg_q[k*DATA_W +: DATA_W] = val_q;
  end
endmodule

// File: rtl/tw_prog_top.sv
module tw_prog_top #(
  parameter int DATA_W    = 17,
  parameter int ADDR_W    = 4,
  parameter int NUM_REGS  = 6,
  parameter int BASE_ADDR = 1,
  parameter int RSV_LO    = 0,
  parameter int RSV_HI    = 15
) (
  input  logic                       clk,
  input  logic                       arst_n,
  input  logic                       ser_clk,
  input  logic                       ser_data,
  input  logic                       ser_en_n,
  input  logic                       divider_read_busy,
  output logic [NUM_REGS*DATA_W-1:0] cfg_q,
  output logic                       addr_err
);
  localparam int SR_W = DATA_W + ADDR_W;

  logic            rst_sync_n;
  logic [1:0]      pins_s;
  logic            en_n_s;
  logic [SR_W-1:0] shift_q;
  logic            load_req;
  logic [NUM_REGS-1:0] latch_we;
  logic            pend_valid;

  tw_prog_rstsync u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_sync_n)
  );

  tw_prog_sync #(.W(2), .RST_VAL(1'b0)) u_sync_cd (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   ({ser_clk, ser_data}),
    .dout  (pins_s)
  );

  tw_prog_sync #(.W(1), .RST_VAL(1'b1)) u_sync_en (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (ser_en_n),
    .dout  (en_n_s)
  );

  tw_prog_shifter #(.SR_W(SR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk_s   (pins_s[1]),
    .sdata_s  (pins_s[0]),
    .en_n_s   (en_n_s),
    .shift_q  (shift_q),
    .load_req (load_req)
  );

  tw_prog_commit #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .BASE_ADDR (BASE_ADDR),
    .RSV_LO    (RSV_LO),
    .RSV_HI    (RSV_HI)
  ) u_commit (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .load_req     (load_req),
    .word         (shift_q),
    .busy         (divider_read_busy),
    .cfg_q        (cfg_q),
    .err_q        (addr_err),
    .latch_we     (latch_we),
    .pend_valid_q (pend_valid)
  );
endmodule

// File: rtl/tw_prog_chk.sv
module tw_prog_chk #(
  parameter int DATA_W   = 17,
  parameter int NUM_REGS = 6,
  parameter int SR_W     = 21
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       busy,
  input logic                       en_n_s,
  input logic [SR_W-1:0]            shift_q,
  input logic [NUM_REGS*DATA_W-1:0] cfg_q,
  input logic                       addr_err,
  input logic [NUM_REGS-1:0]        latch_we,
  input logic                       pend_valid
);
  AST_SHIFT_FROZEN_EN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> $stable(shift_q)); // R2

  AST_SINGLE_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(latch_we)); // R5

  AST_NO_WE_HOLDS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_we == '0) |=> $stable(cfg_q)); // R5

  AST_BUSY_FREEZES_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q)); // R7

  AST_PENDING_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !busy) |=> !pend_valid); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err |=> addr_err); // R10
endmodule

bind tw_prog_top tw_prog_chk #(
  .DATA_W   (DATA_W),
  .NUM_REGS (NUM_REGS),
  .SR_W     (SR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .busy       (divider_read_busy),
  .en_n_s     (en_n_s),
  .shift_q    (shift_q),
  .cfg_q      (cfg_q),
  .addr_err   (addr_err),
  .latch_we   (latch_we),
  .pend_valid (pend_valid)
);

// File: tb/sim_tw_prog_top.sv
`timescale 1ns/1ps
module sim_tw_prog_top;
  localparam int DW = 17;
  localparam int NR = 6;
  localparam int H  = 50;

  logic clk = 1'b0;
  logic arst_n;
  logic ser_clk;
  logic ser_data;
  logic ser_en_n;
  logic divider_read_busy;
  logic [NR*DW-1:0] cfg_q;
  logic addr_err;

  always #2.5 clk = ~clk;

  tw_prog_top u0 (
    .clk               (clk),
    .arst_n            (arst_n),
    .ser_clk           (ser_clk),
    .ser_data          (ser_data),
    .ser_en_n          (ser_en_n),
    .divider_read_busy (divider_read_busy),
    .cfg_q             (cfg_q),
    .addr_err          (addr_err)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [DW-1:0]    mdl [NR];
  logic             mdl_err;
  logic [NR*DW-1:0] exp_flat_q [$];
  logic             exp_err_q  [$];
  string            tag_q      [$];

  function automatic logic [NR*DW-1:0] model_flat();
    logic [NR*DW-1:0] f;
    for (int k = 0; k < NR; k++) f[k*DW +: DW] = mdl[k];
    return f;
  endfunction

  task automatic expect_now(input string tag);
    exp_flat_q.push_back(model_flat());
    exp_err_q.push_back(mdl_err);
    tag_q.push_back(tag);
    #(H/2);
  endtask

  // Monitor: compares the design outputs against each queued expectation.
  initial begin
    forever begin
      logic [NR*DW-1:0] ef;
      logic ee;
      string tg;
      wait (exp_flat_q.size() != 0);
      ef = exp_flat_q.pop_front();
      ee = exp_err_q.pop_front();
      tg = tag_q.pop_front();
      for (int k = 0; k < NR; k++) begin
        n_checks++;
        if (cfg_q[k*DW +: DW] !== ef[k*DW +: DW]) begin
          n_fail++;
          $display("FAIL %s latch%0d actual %h expected %h", tg, k,
                   cfg_q[k*DW +: DW], ef[k*DW +: DW]);
        end
      end
      n_checks++;
      if (addr_err !== ee) begin
        n_fail++;
        $display("FAIL %s addr_err actual %b expected %b", tg, addr_err, ee);
      end
    end
  end

  task automatic clock_bit(input logic b, input bit hold_high);
    ser_data = b;
    #H;
    ser_clk = 1'b1;
    #H;
    if (!hold_high) ser_clk = 1'b0;
  endtask

  task automatic send_frame(input logic [3:0] a, input logic [DW-1:0] d,
                            input int lead, input bit keep_high);
    logic [20:0] w;
    w = {d, a};
    ser_en_n = 1'b0;
    #H;
    for (int i = 0; i < lead; i++) clock_bit(i[0] ? 1'b0 : 1'b1, 1'b0);
    for (int i = 20; i >= 0; i--) clock_bit(w[i], keep_high && i == 0);
    #H;
    ser_en_n = 1'b1;
    #H;
    if (ser_clk) ser_clk = 1'b0;
    #(2*H);
  endtask

  task automatic clocks_en_high(input logic [20:0] w);
    for (int i = 20; i >= 0; i--) clock_bit(w[i], 1'b0);
    #H;
  endtask

  task automatic en_pulse();
    ser_en_n = 1'b0;
    #H;
    ser_en_n = 1'b1;
    #(2*H);
  endtask

  // Watchdog.
  initial begin
    #500us;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // Driver.
  initial begin
    arst_n = 1'b0;
    ser_clk = 1'b0;
    ser_data = 1'b0;
    ser_en_n = 1'b1;
    divider_read_busy = 1'b0;
    for (int k = 0; k < NR; k++) mdl[k] = '0;
    mdl_err = 1'b0;
    #40;
    arst_n = 1'b1;
    #60;
    expect_now("R1 reset");

    send_frame(4'd1, 17'h1A5C3, 0, 1'b0);
    mdl[0] = 17'h1A5C3;
    expect_now("R4 R5 write addr1");

    send_frame(4'd6, 17'h0F0F1, 0, 1'b1);
    mdl[5] = 17'h0F0F1;
    expect_now("R6 enable rises with clk high");

    send_frame(4'd3, 17'h10001, 9, 1'b0);
    mdl[2] = 17'h10001;
    expect_now("R3 leading bits discarded");

    clocks_en_high({17'h15555, 4'd2});
    en_pulse();
    expect_now("R2 clocks with enable high ignored");

    send_frame(4'd1, 17'h00ABC, 0, 1'b0);
    mdl[0] = 17'h00ABC;
    expect_now("R5 overwrite addr1");

    divider_read_busy = 1'b1;
    #H;
    send_frame(4'd4, 17'h12345, 0, 1'b0);
    expect_now("R7 held while busy");
    divider_read_busy = 1'b0;
    #H;
    mdl[3] = 17'h12345;
    expect_now("R7 applied after busy");

    divider_read_busy = 1'b1;
    #H;
    send_frame(4'd2, 17'h0AAAA, 0, 1'b0);
    send_frame(4'd5, 17'h1BEEF, 0, 1'b0);
    expect_now("R8 both held while busy");
    divider_read_busy = 1'b0;
    #H;
    mdl[4] = 17'h1BEEF;
    expect_now("R8 newest request only");

    send_frame(4'd0, 17'h1FFFF, 0, 1'b0);
    mdl_err = 1'b1;
    expect_now("R9 reserved addr0");

    send_frame(4'd15, 17'h0CAFE, 0, 1'b0);
    expect_now("R9 reserved addr15");

    send_frame(4'd9, 17'h07777, 0, 1'b0);
    expect_now("R9 unmapped addr9");

    send_frame(4'd2, 17'h13579, 0, 1'b0);
    mdl[1] = 17'h13579;
    expect_now("R10 error stays after valid write");

    wait (exp_flat_q.size() == 0);
    #20;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule